// File: doc/BRIEF.md
# Protected EEPROM Command Front End

This block decodes the byte stream of a two-wire serial EEPROM after the bits have already been shifted in by a slave interface. The shifter reports start and stop conditions, every received byte, and every moment it needs a byte to send. The block answers each received byte with an acknowledge decision. It turns the command bytes into single-cycle read and write requests for the storage behind it.

Two address spaces sit behind it. The main array is 1 KB, split into eight 128-byte blocks. The block number travels in the device address byte, and the word address byte gives the offset inside the block. A second device address opens a 32-byte configuration space. Offsets 00h to 0Fh of that space hold the access protection page, and offsets 10h to 1Fh hold the ID page.

Before any data byte is written or any byte is read, the block presents the pending address on a lookup port. An external permission input then decides whether the access goes ahead. A busy input marks a running internal write cycle; while it is high, every device address is refused.

Top module: `eepfe_top`

## Requirements
- R1: After reset, ackValid, ackOk, memWr and memRd are 0, and chkAddr is 000h.
- R2: A device byte whose top four bits are 1010b is acknowledged and selects the main array. A device byte with bits [7:1] equal to 1011100b (B8h for write, B9h for read) is acknowledged and selects the configuration space. Any other device byte is NACKed, and every later byte up to the next start condition is also NACKed, with no request issued.
- R3: While busy is high, a device byte that would otherwise match is NACKed.
- R4: In the main array, the word address byte is acknowledged. The pointer becomes {device byte bits [3:1], word byte bits [6:0]}, and bit 7 of the word byte is ignored.
- R5: In the configuration space, a word byte whose bits [7:5] are not all 0 is NACKed. Otherwise the pointer becomes its low five bits, and every request in that space has memCfg=1.
- R6: Each data byte that is accepted is acknowledged. One cycle after the byte, memWr pulses with memAddr at the current pointer and memWData equal to the byte.
- R7: After each written byte, the low four pointer bits step and wrap from 15 to 0. The upper bits never change.
- R8: In a read transaction, each rdReq produces a memRd pulse one cycle later at the current pointer, and the pointer then steps by one. The main pointer wraps from 3FFh to 000h and the configuration pointer from 1Fh to 00h. A read that has no word address starts from wherever the pointer was left.
- R9: A data byte that arrives while permitIn is low is NACKed. No memWr is issued, and the rest of that transaction is NACKed. A rdReq that arrives while permitIn is low produces no memRd and leaves the pointer unchanged.
- R10: chkAddr and chkCfg show the address and space of the next access. chkWrite is 1 exactly while the block is waiting for write data.
- R11: A stop condition ends the transaction, so later bytes are NACKed. A start condition, including a repeated start, expects a device byte next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startEv | input | 1 | Start or repeated start seen |
| stopEv | input | 1 | Stop seen |
| byteValid | input | 1 | A byte from the master is complete |
| byteData | input | 8 | Received byte, MSB first on the wire |
| rdReq | input | 1 | Shifter needs the next byte to transmit |
| busy | input | 1 | Internal write cycle in progress |
| permitIn | input | 1 | Permission for the access shown on the chk ports |
| chkAddr | output | 10 | Address of the pending access |
| chkCfg | output | 1 | Pending access targets the configuration space |
| chkWrite | output | 1 | Pending access is a write |
| ackValid | output | 1 | Acknowledge decision is valid |
| ackOk | output | 1 | 1 = ACK, 0 = NACK |
| memWr | output | 1 | Write request pulse |
| memRd | output | 1 | Read request pulse |
| memCfg | output | 1 | Request targets the configuration space |
| memAddr | output | 10 | Request address |
| memWData | output | 8 | Write data |

## Verification
The bench uses the default parameters: three block bits, a seven-bit offset, four page bits and five configuration bits. With these values both wrap points are only a few bytes away. A page write starting at offset 0Eh reaches the in-page wrap on its third byte. A sequential read from 3FFh or 1Fh reaches the end-of-space wrap on its second request. The default device codes let B8h/B9h, block-coded main addresses and a foreign address such as 50h all be tried in the same run.

// File: rtl/eepfe_pkg.sv
package eepfe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_WORD, ST_WDATA, ST_READ, ST_SKIP
  } feState_t;

  typedef struct packed {
    logic pickSpace;  // device byte accepted
    logic toCfg;      // chosen space is the configuration space
    logic loadWord;   // word address accepted
    logic issueWr;
    logic issueRd;
    logic stepPage;   // in-page increment
    logic stepSeq;    // linear increment
  } feStrobe_t;
endpackage

// File: rtl/eepfe_ctrl.sv
module eepfe_ctrl
  import eepfe_pkg::*;
#(
  parameter int BLK_BITS  = 3,
  parameter int CFG_BITS  = 5,
  parameter int MAIN_CODE = 'hA,
  parameter int CFG_DEV   = 'h5C
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  input  logic       rdReq,
  input  logic       busy,
  input  logic       permitIn,
  input  logic       spaceCfg,
  output feStrobe_t  strobe,
  output feState_t   state,
  output logic       ackValid,
  output logic       ackOk
);
  localparam int CODE_W = 7 - BLK_BITS;

  feState_t nxt;
  logic     ackNext;
  logic     isMain, isCfg;

  assign isMain = (byteData[7:BLK_BITS+1] == MAIN_CODE[CODE_W-1:0]);
  assign isCfg  = (byteData[7:1] == CFG_DEV[6:0]);

  always_comb begin
    strobe  = '0;
    nxt     = state;
    ackNext = 1'b0;
    if (startEv) begin
      nxt = ST_DEV;
    end else if (stopEv) begin
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_DEV: if (byteValid) begin
          if (!busy && (isMain || isCfg)) begin
            ackNext          = 1'b1;
            strobe.pickSpace = 1'b1;
            strobe.toCfg     = isCfg;
            nxt              = byteData[0] ? ST_READ : ST_WORD;
          end else begin
            nxt = ST_SKIP;
          end
        end
        ST_WORD: if (byteValid) begin
          if (spaceCfg && (byteData[7:CFG_BITS] != '0)) begin
            nxt = ST_SKIP;
          end else begin
            ackNext         = 1'b1;
            strobe.loadWord = 1'b1;
            nxt             = ST_WDATA;
          end
        end
        ST_WDATA: if (byteValid) begin
          if (permitIn) begin
            ackNext         = 1'b1;
            strobe.issueWr  = 1'b1;
            strobe.stepPage = 1'b1;
          end else begin
            nxt = ST_SKIP;
          end
        end
        ST_READ: if (rdReq && permitIn) begin
          strobe.issueRd = 1'b1;
          strobe.stepSeq = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ackValid <= 1'b0;
      ackOk    <= 1'b0;
    end else begin
      state    <= nxt;
      ackValid <= byteValid;
      ackOk    <= ackNext;
    end
  end
endmodule

// File: rtl/eepfe_dpath.sv
module eepfe_dpath
  import eepfe_pkg::*;
#(
  parameter int BLK_BITS  = 3,
  parameter int OFF_BITS  = 7,
  parameter int PAGE_BITS = 4,
  parameter int CFG_BITS  = 5,
  localparam int ADDR_W   = BLK_BITS + OFF_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  feStrobe_t         strobe,
  input  logic [7:0]        byteData,
  output logic              spaceCfg,
  output logic [ADDR_W-1:0] curAddr,
  output logic              memWr,
  output logic              memRd,
  output logic              memCfg,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWData
);
  logic [BLK_BITS-1:0] blk;
  logic [ADDR_W-1:0]   mainPtr, mainPage, mainSeq;
  logic [CFG_BITS-1:0] cfgPtr, cfgPage, cfgSeq;

  assign mainPage = {mainPtr[ADDR_W-1:PAGE_BITS], mainPtr[PAGE_BITS-1:0] + 1'b1};
  assign mainSeq  = mainPtr + 1'b1;
  assign cfgPage  = {cfgPtr[CFG_BITS-1:PAGE_BITS], cfgPtr[PAGE_BITS-1:0] + 1'b1};
  assign cfgSeq   = cfgPtr + 1'b1;
  assign curAddr  = spaceCfg ? {{(ADDR_W-CFG_BITS){1'b0}}, cfgPtr} : mainPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blk      <= '0;
      spaceCfg <= 1'b0;
      mainPtr  <= '0;
      cfgPtr   <= '0;
      memWr    <= 1'b0;
      memRd    <= 1'b0;
      memCfg   <= 1'b0;
      memAddr  <= '0;
      memWData <= '0;
    end else begin
      memWr <= strobe.issueWr;
      memRd <= strobe.issueRd;
      if (strobe.issueWr || strobe.issueRd) begin
        memCfg  <= spaceCfg;
        memAddr <= curAddr;
      end
      if (strobe.issueWr) memWData <= byteData;
      if (strobe.pickSpace) begin
        spaceCfg <= strobe.toCfg;
        if (!strobe.toCfg) blk <= byteData[BLK_BITS:1];
      end
      if (strobe.loadWord) begin
        if (spaceCfg) cfgPtr  <= byteData[CFG_BITS-1:0];
        else          mainPtr <= {blk, byteData[OFF_BITS-1:0]};
      end
      if (strobe.stepPage) begin
        if (spaceCfg) cfgPtr  <= cfgPage;
        else          mainPtr <= mainPage;
      end
      if (strobe.stepSeq) begin
        if (spaceCfg) cfgPtr  <= cfgSeq;
        else          mainPtr <= mainSeq;
      end
    end
  end
endmodule

// File: rtl/eepfe_top.sv
module eepfe_top
  import eepfe_pkg::*;
#(
  parameter int BLK_BITS  = 3,
  parameter int OFF_BITS  = 7,
  parameter int PAGE_BITS = 4,
  parameter int CFG_BITS  = 5,
  parameter int MAIN_CODE = 'hA,
  parameter int CFG_DEV   = 'h5C
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         startEv,
  input  logic                         stopEv,
  input  logic                         byteValid,
  input  logic [7:0]                   byteData,
  input  logic                         rdReq,
  input  logic                         busy,
  input  logic                         permitIn,
  output logic [BLK_BITS+OFF_BITS-1:0] chkAddr,
  output logic                         chkCfg,
  output logic                         chkWrite,
  output logic                         ackValid,
  output logic                         ackOk,
  output logic                         memWr,
  output logic                         memRd,
  output logic                         memCfg,
  output logic [BLK_BITS+OFF_BITS-1:0] memAddr,
  output logic [7:0]                   memWData
);
  localparam int ADDR_W = BLK_BITS + OFF_BITS;

  feStrobe_t strobe;
  feState_t  ctrlState;
  logic      spaceCfg;

  eepfe_ctrl #(
    .BLK_BITS(BLK_BITS), .CFG_BITS(CFG_BITS),
    .MAIN_CODE(MAIN_CODE), .CFG_DEV(CFG_DEV)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .byteValid(byteValid), .byteData(byteData), .rdReq(rdReq),
    .busy(busy), .permitIn(permitIn), .spaceCfg(spaceCfg),
    .strobe(strobe), .state(ctrlState), .ackValid(ackValid), .ackOk(ackOk)
  );

  eepfe_dpath #(
    .BLK_BITS(BLK_BITS), .OFF_BITS(OFF_BITS),
    .PAGE_BITS(PAGE_BITS), .CFG_BITS(CFG_BITS)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteData(byteData),
    .spaceCfg(spaceCfg), .curAddr(chkAddr), .memWr(memWr), .memRd(memRd),
    .memCfg(memCfg), .memAddr(memAddr), .memWData(memWData)
  );

  assign chkCfg   = spaceCfg;
  assign chkWrite = (ctrlState == ST_WDATA);
endmodule

// File: rtl/eepfe_check.sv
module eepfe_check
  import eepfe_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int PAGE_BITS = 4,
  parameter int CFG_BITS  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              startEv,
  input logic              stopEv,
  input logic              byteValid,
  input logic              rdReq,
  input logic              busy,
  input logic              permitIn,
  input feState_t          ctrlState,
  input logic              ackValid,
  input logic              ackOk,
  input logic              memWr,
  input logic              memRd,
  input logic              memCfg,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] chkAddr
);
  assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(byteValid));

  assert_busy_nack_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_DEV && byteValid && busy && !startEv && !stopEv)
      |=> (ackValid && !ackOk));

  assert_cfg_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memCfg && (memWr || memRd)) |-> (memAddr[ADDR_W-1:CFG_BITS] == '0));

  assert_wr_acked_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> (ackValid && ackOk && !memRd));

  assert_page_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> (chkAddr[ADDR_W-1:PAGE_BITS] == memAddr[ADDR_W-1:PAGE_BITS]));

  assert_read_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_READ && rdReq && !permitIn && !startEv && !stopEv)
      |=> !memRd);
endmodule

bind eepfe_top eepfe_check #(
  .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .CFG_BITS(CFG_BITS)
) uChk (
  .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
  .byteValid(byteValid), .rdReq(rdReq), .busy(busy), .permitIn(permitIn),
  .ctrlState(ctrlState), .ackValid(ackValid), .ackOk(ackOk),
  .memWr(memWr), .memRd(memRd), .memCfg(memCfg), .memAddr(memAddr),
  .chkAddr(chkAddr)
);

// File: tb/sim_eepfe_top.sv
`timescale 1ns/1ps
module sim_eepfe_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startEv = 1'b0, stopEv = 1'b0, byteValid = 1'b0, rdReq = 1'b0;
  logic       busy = 1'b0, permitIn = 1'b1;
  logic [7:0] byteData = 8'h00;
  logic [9:0] chkAddr, memAddr;
  logic       chkCfg, chkWrite, ackValid, ackOk, memWr, memRd, memCfg;
  logic [7:0] memWData;

  int  nChecks = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  logic       sAck, sWr, sRd, sCfg;
  logic [9:0] sAddr;
  logic [7:0] sData;

  always #2.5 clk = ~clk;

  eepfe_top u0 (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .byteValid(byteValid), .byteData(byteData), .rdReq(rdReq), .busy(busy),
    .permitIn(permitIn), .chkAddr(chkAddr), .chkCfg(chkCfg), .chkWrite(chkWrite),
    .ackValid(ackValid), .ackOk(ackOk), .memWr(memWr), .memRd(memRd),
    .memCfg(memCfg), .memAddr(memAddr), .memWData(memWData)
  );

  task automatic chkEq(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic grab();
    sAck = ackValid && ackOk; sWr = memWr; sRd = memRd;
    sCfg = memCfg; sAddr = memAddr; sData = memWData;
  endtask

  task automatic doStart();
    @(negedge clk) startEv = 1'b1;
    @(negedge clk) startEv = 1'b0;
  endtask

  task automatic doStop();
    @(negedge clk) stopEv = 1'b1;
    @(negedge clk) stopEv = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk) begin byteValid = 1'b1; byteData = b; end
    @(negedge clk) begin byteValid = 1'b0; grab(); end
  endtask

  task automatic pullByte();
    @(negedge clk) rdReq = 1'b1;
    @(negedge clk) begin rdReq = 1'b0; grab(); end
  endtask

  task automatic wrExpect(input string tag, input logic [7:0] b,
                          input logic [9:0] a, input logic c);
    sendByte(b);
    chkEq(tag, "data ack", sAck, 1);
    chkEq(tag, "memWr", sWr, 1);
    chkEq(tag, "wr addr", sAddr, a);
    chkEq(tag, "wr cfg", sCfg, c);
    chkEq(tag, "wr data", sData, b);
  endtask

  task automatic rdExpect(input string tag, input logic [9:0] a, input logic c);
    pullByte();
    chkEq(tag, "memRd", sRd, 1);
    chkEq(tag, "rd addr", sAddr, a);
    chkEq(tag, "rd cfg", sCfg, c);
  endtask

  task automatic nackExpect(input string tag, input logic [7:0] b);
    sendByte(b);
    chkEq(tag, "nack", sAck, 0);
    chkEq(tag, "no write", sWr, 0);
  endtask

  task automatic testReset();
    chkEq("R1", "ackValid", ackValid, 0);
    chkEq("R1", "memWr", memWr, 0);
    chkEq("R1", "memRd", memRd, 0);
    chkEq("R1", "chkAddr", chkAddr, 10'h000);
  endtask

  task automatic testByteWrite();
    doStart();
    sendByte(8'hA6); chkEq("R2", "main dev ack", sAck, 1);
    sendByte(8'h85); chkEq("R4", "word ack", sAck, 1);
    chkEq("R10", "chkWrite", chkWrite, 1);
    chkEq("R4", "chkAddr blk3 off05", chkAddr, 10'h185);
    wrExpect("R6", 8'h5A, 10'h185, 1'b0);
    doStop();
  endtask

  task automatic testPageWrap();
    doStart(); sendByte(8'hA0); sendByte(8'h0E);
    wrExpect("R7", 8'h11, 10'h00E, 1'b0);
    wrExpect("R7", 8'h22, 10'h00F, 1'b0);
    wrExpect("R7", 8'h33, 10'h000, 1'b0);
    chkEq("R10", "next addr", chkAddr, 10'h001);
    doStop();
  endtask

  task automatic testSeqRead();
    doStart(); sendByte(8'hAE); sendByte(8'h7F);
    chkEq("R4", "ptr 3FF", chkAddr, 10'h3FF);
    doStart(); sendByte(8'hAF); chkEq("R11", "restart read ack", sAck, 1);
    chkEq("R10", "chkWrite low in read", chkWrite, 0);
    rdExpect("R8", 10'h3FF, 1'b0);
    rdExpect("R8", 10'h000, 1'b0);
    doStop();
    doStart(); sendByte(8'hA1);
    rdExpect("R8", 10'h001, 1'b0);
    doStop();
  endtask

  task automatic testCfg();
    doStart(); sendByte(8'hB8); chkEq("R2", "cfg dev ack", sAck, 1);
    chkEq("R5", "chkCfg", chkCfg, 1);
    nackExpect("R5", 8'h20);
    nackExpect("R5", 8'h44);
    doStop();
    doStart(); sendByte(8'hB8); sendByte(8'h1E);
    chkEq("R5", "word ack", sAck, 1);
    wrExpect("R7", 8'hC1, 10'h01E, 1'b1);
    wrExpect("R7", 8'hC2, 10'h01F, 1'b1);
    wrExpect("R7", 8'hC3, 10'h010, 1'b1);
    doStop();
    doStart(); sendByte(8'hB8); sendByte(8'h1F);
    doStart(); sendByte(8'hB9); chkEq("R2", "cfg read ack", sAck, 1);
    rdExpect("R8", 10'h01F, 1'b1);
    rdExpect("R8", 10'h000, 1'b1);
    doStop();
  endtask

  task automatic testForeign();
    doStart();
    nackExpect("R2", 8'h50);
    nackExpect("R2", 8'h10);
    doStop();
  endtask

  task automatic testBusy();
    busy = 1'b1;
    doStart(); nackExpect("R3", 8'hA0); doStop();
    doStart(); nackExpect("R3", 8'hB8); doStop();
    busy = 1'b0;
  endtask

  task automatic testPermit();
    doStart(); sendByte(8'hA0); sendByte(8'h30);
    permitIn = 1'b0;
    nackExpect("R9", 8'h77);
    permitIn = 1'b1;
    nackExpect("R9", 8'h78);
    doStop();
    doStart(); sendByte(8'hA1);
    permitIn = 1'b0;
    pullByte(); chkEq("R9", "read blocked", sRd, 0);
    permitIn = 1'b1;
    rdExpect("R9", 10'h030, 1'b0);
    doStop();
  endtask

  task automatic testStop();
    doStart(); sendByte(8'hA0); sendByte(8'h10);
    doStop();
    nackExpect("R11", 8'h99);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    @(negedge clk) rstN = 1'b1;
    testByteWrite();
    testPageWrap();
    testSeqRead();
    testCfg();
    testForeign();
    testBusy();
    testPermit();
    testStop();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end
endmodule